// File: doc/BRIEF.md
# Jump-and-Link Return Address Predictor

This block handles the control side of a register-indirect jump-and-link instruction in a 64-bit pipeline and keeps a small circular return address stack. Each cycle it may receive one decoded jump: a valid bit, the destination and base register numbers, a flag that says the immediate equals 8, the PC of the jump, the computed target address, and the address-mask mode bit.

In the same cycle, with no register in the path, the block produces the link value and its write enable, so the instruction in the delay slot can read the result. It also raises a trap when the target is not word aligned. A jump that links through register 15 is treated as a call and pushes its return address. The two return encodings are predicted from the top of the stack, and that entry is popped. One cycle later a flag reports whether the prediction was wrong.

Top module: `jl_ras`

## Requirements
- R1: For an accepted jump with an aligned target and a nonzero destination, `link_we` is high and `link_data` equals the jump's own PC, both in the same cycle the jump is presented.
- R2: When `in_amask` is 1, the upper half of `link_data` is zero, and any address pushed onto the stack has its upper half cleared as well.
- R3: A jump with destination 0 never asserts `link_we` and never pushes.
- R4: An aligned jump with destination 15 pushes its PC plus 8 onto the return stack.
- R5: An aligned jump with destination 0, immediate 8 and base register 31 or 15 is a return. When the stack holds an entry, that jump gets `pred_valid` high and `pred_target` set to the most recently pushed entry, and the entry is popped.
- R6: Any other jump with destination 0 leaves `pred_valid` low and does not change the stack.
- R7: If bit 1 or bit 0 of the target is 1, `trap_misalign` is high in the same cycle. For that jump, `link_we` is low, `fault_log_we` is low, no prediction is given, and the stack is unchanged. When there is no trap, `fault_log_we` follows `in_fault_req` for accepted jumps.
- R8: The stack is circular with `DEPTH` entries. A push made while it is full overwrites the oldest entry, so the `DEPTH` most recent addresses stay poppable.
- R9: A return issued while the stack is empty gives `pred_valid` low and leaves the stack unchanged.
- R10: `mispredict` is high in the cycle after an untrapped return whose prediction was invalid or differed from `in_target`, and low after every other cycle.
- R11: Synchronous reset empties the stack and clears `mispredict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A jump is presented this cycle |
| in_rd | input | 5 | Destination register number |
| in_rs1 | input | 5 | Base register number |
| in_imm_is8 | input | 1 | Immediate operand equals 8 |
| in_pc | input | XLEN | PC of the jump |
| in_target | input | XLEN | Computed (resolved) target address |
| in_amask | input | 1 | Address-mask mode |
| in_fault_req | input | 1 | Request to log a data fault for this instruction |
| link_data | output | XLEN | Value written to the destination register |
| link_we | output | 1 | Destination register write enable |
| trap_misalign | output | 1 | Misaligned target trap |
| fault_log_we | output | 1 | Update strobe for the fault status and address registers |
| pred_valid | output | 1 | Return prediction is valid |
| pred_target | output | XLEN | Predicted return address |
| mispredict | output | 1 | Previous return was mispredicted |

## Verification
The bench builds the block with `DEPTH` = 4 and `XLEN` = 64. The small depth makes wrap-around, overwrite of the oldest entry and underflow reachable within a few instructions. For every push count from 0 to 6 it issues two more returns than pushes, and it also sweeps all 32 destination registers and every misaligned low-bit pattern. A model of the circular stack inside the bench supplies each expected prediction and misprediction.

// File: rtl/jl_ras.sv
module jl_ras #(
  parameter int XLEN  = 64,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [4:0]      in_rd,
  input  logic [4:0]      in_rs1,
  input  logic            in_imm_is8,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_target,
  input  logic            in_amask,
  input  logic            in_fault_req,
  output logic [XLEN-1:0] link_data,
  output logic            link_we,
  output logic            trap_misalign,
  output logic            fault_log_we,
  output logic            pred_valid,
  output logic [XLEN-1:0] pred_target,
  output logic            mispredict
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = XLEN / 2;

  logic [AW-1:0]    sp;
  logic [DEPTH-1:0] vld;
  logic [XLEN-1:0]  ent [DEPTH];

  logic [AW-1:0]   top;
  logic [XLEN-1:0] mask, push_val;
  logic            is_call, is_ret, hit;

  assign top      = sp - AW'(1);
  assign mask     = {{HALF{~in_amask}}, {HALF{1'b1}}};
  assign push_val = (in_pc + XLEN'(8)) & mask;

  assign trap_misalign = in_valid & (|in_target[1:0]);
  assign link_data     = in_pc & mask;
  assign link_we       = in_valid & (in_rd != 5'd0) & ~trap_misalign;
  assign fault_log_we  = in_valid & in_fault_req & ~trap_misalign;

  assign is_call = in_valid & ~trap_misalign & (in_rd == 5'd15);
  assign is_ret  = in_valid & ~trap_misalign & (in_rd == 5'd0) & in_imm_is8 &
                   ((in_rs1 == 5'd31) | (in_rs1 == 5'd15));
  assign hit     = is_ret & vld[top];

  assign pred_valid  = hit;
  assign pred_target = hit ? ent[top] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp         <= '0;
      vld        <= '0;
      mispredict <= 1'b0;
    end else begin
      mispredict <= is_ret & (~vld[top] | (ent[top] != in_target));
      if (is_call) begin
        vld[sp] <= 1'b1;
        sp      <= sp + AW'(1);
      end else if (hit) begin
        vld[top] <= 1'b0;
        sp       <= top;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (is_call) ent[sp] <= push_val;
  end
endmodule

module jl_ras_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [4:0]      in_rd,
  input logic            in_imm_is8,
  input logic [XLEN-1:0] in_target,
  input logic            in_amask,
  input logic [XLEN-1:0] link_data,
  input logic            link_we,
  input logic            trap_misalign,
  input logic            fault_log_we,
  input logic            pred_valid,
  input logic            mispredict
);
  p_amask_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_amask) |-> (link_data[XLEN-1:XLEN/2] == '0));

  p_no_link_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rd == 5'd0) |-> !link_we);

  p_pred_decode_r5: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (in_valid && in_rd == 5'd0 && in_imm_is8));

  p_trap_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    trap_misalign |-> (!link_we && !fault_log_we && !pred_valid));

  p_mispred_src_r10: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(in_valid && in_rd == 5'd0 && in_imm_is8 && in_target[1:0] == 2'b00));

  p_reset_r11: assert property (@(posedge clk)
    rst |=> !mispredict);
endmodule

bind jl_ras jl_ras_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_jl_ras.sv
module sim_jl_ras;
  localparam int DEPTH = 4;

  logic        clk = 0, rst = 1;
  logic        in_valid = 0, in_imm_is8 = 0, in_amask = 0, in_fault_req = 0;
  logic [4:0]  in_rd = 0, in_rs1 = 0;
  logic [63:0] in_pc = 0, in_target = 0;
  logic [63:0] link_data, pred_target;
  logic        link_we, trap_misalign, fault_log_we, pred_valid, mispredict;

  jl_ras #(.XLEN(64), .DEPTH(DEPTH)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "";
  logic [63:0] md [DEPTH];
  bit mv [DEPTH];
  int msp = 0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", phase, tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0;
    @(posedge clk); #1; rst = 0;
    for (int i = 0; i < DEPTH; i++) mv[i] = 0;
    msp = 0;
  endtask

  function automatic int tidx();
    return (msp + DEPTH - 1) % DEPTH;
  endfunction

  task automatic issue(input logic [4:0] rd, input logic [4:0] rs1, input logic imm8,
                       input logic [63:0] pc, input logic [63:0] tgt,
                       input logic am, input logic fr);
    logic mis, call, ret, epv;
    logic [63:0] mask, ept;
    int t;
    @(negedge clk);
    in_valid = 1; in_rd = rd; in_rs1 = rs1; in_imm_is8 = imm8;
    in_pc = pc; in_target = tgt; in_amask = am; in_fault_req = fr;
    #5;
    mis  = |tgt[1:0];
    mask = am ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
    call = (rd == 5'd15) && !mis;
    ret  = (rd == 5'd0) && imm8 && (rs1 == 5'd15 || rs1 == 5'd31) && !mis;
    t    = tidx();
    epv  = ret && mv[t];
    ept  = epv ? md[t] : 64'd0;
    chk(link_data, pc & mask, am ? "R2 link" : "R1 link");
    chk({63'd0, link_we}, {63'd0, (rd != 5'd0) && !mis}, rd == 5'd0 ? "R3 we" : "R1 we");
    chk({63'd0, trap_misalign}, {63'd0, mis}, "R7 trap");
    chk({63'd0, fault_log_we}, {63'd0, fr && !mis}, "R7 fault");
    chk({63'd0, pred_valid}, {63'd0, epv}, ret ? (mv[t] ? "R5 pv" : "R9 pv") : "R6 pv");
    if (epv) chk(pred_target, ept, "R5 target");
    @(posedge clk); #1;
    chk({63'd0, mispredict}, {63'd0, ret && (!epv || ept != tgt)}, "R10 mispredict");
    if (call) begin
      md[msp] = (pc + 64'd8) & mask;  // R4
      mv[msp] = 1;
      msp = (msp + 1) % DEPTH;
    end else if (epv) begin
      mv[t] = 0;
      msp = t;
    end
  endtask

  task automatic ret_from(input logic [4:0] rs1, input bit wrong);
    logic [63:0] tg;
    int t;
    t  = tidx();
    tg = mv[t] ? md[t] : 64'h0000_0000_0000_4000;
    if (wrong) tg = tg + 64'd4;
    issue(5'd0, rs1, 1'b1, 64'h0000_0000_0000_9000, tg, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    phase = "R11";
    @(negedge clk); #5;
    chk({63'd0, link_we}, 64'd0, "R11 we");
    chk({63'd0, pred_valid}, 64'd0, "R11 pv");
    chk({63'd0, mispredict}, 64'd0, "R11 mispredict");
    chk({63'd0, trap_misalign}, 64'd0, "R11 trap");
    ret_from(5'd31, 0);

    phase = "sweep";
    for (int r = 0; r < 32; r++)
      issue(5'(r), 5'd3, 1'b0, {32'hC0DE_0000 + 32'(r), 32'h0001_0000 + 32'(r * 16)},
            64'h0000_0000_0000_2000, r[0], r[1]);
    ret_from(5'd15, 0);
    ret_from(5'd31, 0);

    phase = "R11";
    issue(5'd15, 5'd1, 1'b0, 64'h0000_0000_0000_1000, 64'h2000, 1'b0, 1'b0);
    issue(5'd15, 5'd1, 1'b0, 64'h0000_0000_0000_1100, 64'h2000, 1'b0, 1'b0);
    do_reset();
    ret_from(5'd31, 0);

    for (int k = 0; k <= 6; k++) begin
      do_reset();
      phase = (k > DEPTH) ? "R8" : "R4";
      for (int i = 0; i < k; i++)
        issue(5'd15, 5'(i), 1'b0, {32'hA5A5_0000 + 32'(k * 8 + i), 32'h0000_1000 + 32'(i * 64)},
              64'h0000_0000_0000_3000, i[0], 1'b0);
      phase = (k > DEPTH) ? "R8" : "R5";
      for (int j = 0; j < k + 2; j++)
        ret_from(j[0] ? 5'd15 : 5'd31, j == 1);
    end

    phase = "R7";
    do_reset();
    issue(5'd15, 5'd1, 1'b0, 64'h0000_0000_0000_5000, 64'h2000, 1'b0, 1'b0);
    for (int lo = 1; lo < 4; lo++) begin
      issue(5'd0, 5'd31, 1'b1, 64'h6000, 64'h0000_0000_0000_5008 + 64'(lo), 1'b0, 1'b1);
      issue(5'd15, 5'd2, 1'b0, 64'h7000, 64'h0000_0000_0000_8000 + 64'(lo), 1'b0, 1'b1);
      issue(5'd7, 5'd2, 1'b0, 64'h7100, 64'h0000_0000_0000_8000 + 64'(lo), 1'b1, 1'b1);
    end
    issue(5'd9, 5'd2, 1'b0, 64'h7200, 64'h8000, 1'b0, 1'b1);

    phase = "R6";
    issue(5'd0, 5'd31, 1'b0, 64'h7300, 64'h8000, 1'b0, 1'b0);
    issue(5'd0, 5'd14, 1'b1, 64'h7400, 64'h8000, 1'b0, 1'b0);
    issue(5'd0, 5'd1, 1'b1, 64'h7500, 64'h8000, 1'b0, 1'b0);
    phase = "R5";
    ret_from(5'd31, 0);
    ret_from(5'd31, 0);

    @(negedge clk); in_valid = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule